// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block predicts the value that a pointer-producing load will return, using the difference between the load's effective address and the data it fetched. When a load retires in normal mode, it arrives on the training port with its program counter, effective address and loaded value. The block computes `delta = address - value`. If that delta is small, the loaded value is probably an address, and the block records the delta in a small set-associative table keyed by the program counter. A per-entry confidence counter tracks whether the same delta keeps recurring.

During runahead mode, a load that misses the last-level cache is presented on the lookup port with its program counter and effective address. If a matching entry has enough confidence, the block returns `address - stored delta` as the predicted load value, one clock later. Lookups only read the table, so a wrong prediction needs no repair of any state.

The table is indexed by the low program counter bits. The remaining upper bits are XOR-folded into a short tag. The table has an invalid-first, then least-recently-used allocation policy per set.

Top module: `avd_predictor`

## Requirements
- R1: After reset every entry is invalid and `pred_vld` is 0, so no lookup predicts until three in-range trainings of one PC have occurred.
- R2: The training delta is `trn_ea - trn_data` (64-bit two's complement). A valid prediction equals `lk_ea` minus the stored delta, sign-extended from 17 bits.
- R3: Training is accepted only when the delta, read as a signed number, lies in -65535 to +65535 inclusive. Other trainings leave the table unchanged.
- R4: A training hit with the same delta increments the 3-bit confidence, which saturates at 7. A prediction is valid only when confidence is at least 2.
- R5: A training hit with a different delta stores the new delta and resets confidence to 0.
- R6: The set index is `pc[1:0]` and each set has 4 ways. A training miss allocates the lowest-numbered invalid way, otherwise the least recently trained way, with confidence 0. At most one entry becomes valid per cycle.
- R7: A lookup presented at one clock edge drives `pred_vld`/`pred_value` after that edge. A training in the same cycle is not visible to that lookup.
- R8: Lookups never modify the table; a lookup never allocates or trains an entry.
- R9: A lookup hits only when the folded tag of `lk_pc` matches a valid entry in its set. The tag is `pc[9:2]` when `pc` bits above 9 are zero.
- R10: `pred_vld` is 1 only in the cycle after one in which `lk_vld` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trn_vld | input | 1 | Retired normal-mode load present |
| trn_pc | input | 64 | Program counter of the retired load |
| trn_ea | input | 64 | Effective address of the retired load |
| trn_data | input | 64 | Value returned by the retired load |
| lk_vld | input | 1 | Runahead last-level-miss load present |
| lk_pc | input | 64 | Program counter of the missing load |
| lk_ea | input | 64 | Effective address of the missing load |
| pred_vld | output | 1 | Registered: prediction available |
| pred_value | output | 64 | Registered: predicted load value |

## Verification
The assertions assume the training and lookup ports carry at most one load each per cycle. They also assume the reset is asserted before the first clock edge. With those assumptions, a valid prediction always lies within the filter range of the previous lookup address, and rejected or absent trainings never alter the valid bits. The stimulus drives each port for one cycle at a time from the falling edge. All program counters have zero bits above bit 9, so set and tag conflicts are chosen deliberately. Same-cycle training and lookup appear only in the dedicated hazard test.

// File: rtl/avd_pkg.sv
package avd_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_BUMP    = 2'd1,
    UPD_RETRAIN = 2'd2,
    UPD_ALLOC   = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/avd_filter.sv
// Delta computation and range filter for a training load.
module avd_filter #(
  parameter int ADDR_W  = 64,
  parameter int DELTA_W = 17,
  parameter int MAX_AVD = 65535
) (
  input  logic [ADDR_W-1:0]  ea,
  input  logic [ADDR_W-1:0]  data,
  output logic [DELTA_W-1:0] delta,
  output logic               in_range
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(MAX_AVD);

  logic [ADDR_W-1:0] diff;

  assign diff     = ea - data;
  assign in_range = ($signed(diff) <= $signed(LIM)) && ($signed(diff) >= -$signed(LIM));
  assign delta    = diff[DELTA_W-1:0];
endmodule

// File: rtl/avd_match.sv
// Tag compare across the ways of one set.
module avd_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vset,
  input  logic [WAYS-1:0][TAG_W-1:0] tset,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vset[w] && (tset[w] == tag)) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/avd_victim.sv
// Replacement choice: lowest invalid way, else the oldest way.
module avd_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vset,
  input  logic [WAYS-1:0][WAY_W-1:0] aset,
  output logic [WAY_W-1:0]           way
);
  always_comb begin
    logic found;
    found = 1'b0;
    way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vset[w]) begin
        found = 1'b1;
        way   = WAY_W'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (aset[w] == WAY_W'(WAYS - 1)) way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/avd_predictor.sv
// Address-value delta predictor: training port, lookup port, set-associative table.
module avd_predictor
  import avd_pkg::*;
#(
  parameter int PC_W    = 64,
  parameter int ADDR_W  = 64,
  parameter int SETS    = 4,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 8,
  parameter int DELTA_W = 17,
  parameter int CONF_W  = 3,
  parameter int CONF_TH = 2,
  parameter int MAX_AVD = 65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trn_vld,
  input  logic [PC_W-1:0]   trn_pc,
  input  logic [ADDR_W-1:0] trn_ea,
  input  logic [ADDR_W-1:0] trn_data,
  input  logic              lk_vld,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [ADDR_W-1:0] lk_ea,
  output logic              pred_vld,
  output logic [ADDR_W-1:0] pred_value
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT   = SETS * WAYS;
  localparam int ENT_W = IDX_W + WAY_W;
  localparam int UP_W  = PC_W - IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX  = '1;
  localparam logic [CONF_W-1:0] CONF_TH_V = CONF_W'(CONF_TH);

  function automatic logic [TAG_W-1:0] fold_tag(input logic [PC_W-1:0] pc);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int i = 0; i < UP_W; i++) t[i % TAG_W] = t[i % TAG_W] ^ pc[IDX_W + i];
    return t;
  endfunction

  // table state
  logic [ENT-1:0]     valid_q, valid_d;
  logic [CONF_W-1:0]  conf_q  [ENT];
  logic [CONF_W-1:0]  conf_d  [ENT];
  logic [WAY_W-1:0]   age_q   [ENT];
  logic [WAY_W-1:0]   age_d   [ENT];
  logic [TAG_W-1:0]   tag_q   [ENT];
  logic [DELTA_W-1:0] delta_q [ENT];

  // training side
  logic [IDX_W-1:0]             t_idx;
  logic [TAG_W-1:0]             t_tag;
  logic [DELTA_W-1:0]           trn_delta;
  logic                         trn_in_range;
  logic [WAYS-1:0]              t_vset;
  logic [WAYS-1:0][TAG_W-1:0]   t_tset;
  logic [WAYS-1:0][WAY_W-1:0]   t_aset;
  logic                         t_hit;
  logic [WAY_W-1:0]             t_way, v_way, tgt_way;
  logic [ENT_W-1:0]             tgt;
  upd_kind_e                    kind;
  logic                         upd_en, meta_en;

  // lookup side
  logic [IDX_W-1:0]             l_idx;
  logic [TAG_W-1:0]             l_tag;
  logic [WAYS-1:0]              l_vset;
  logic [WAYS-1:0][TAG_W-1:0]   l_tset;
  logic                         l_hit;
  logic [WAY_W-1:0]             l_way;
  logic [ENT_W-1:0]             l_ent;
  logic [DELTA_W-1:0]           l_delta;
  logic                         pred_ok;
  logic [ADDR_W-1:0]            pred_val_d;
  logic                         pred_vld_q;
  logic [ADDR_W-1:0]            pred_value_q;

  assign t_idx = trn_pc[IDX_W-1:0];
  assign t_tag = fold_tag(trn_pc);
  assign l_idx = lk_pc[IDX_W-1:0];
  assign l_tag = fold_tag(lk_pc);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      t_vset[w] = valid_q[{t_idx, WAY_W'(w)}];
      t_tset[w] = tag_q[{t_idx, WAY_W'(w)}];
      t_aset[w] = age_q[{t_idx, WAY_W'(w)}];
      l_vset[w] = valid_q[{l_idx, WAY_W'(w)}];
      l_tset[w] = tag_q[{l_idx, WAY_W'(w)}];
    end
  end

  avd_filter #(.ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .MAX_AVD(MAX_AVD)) u_filt (
    .ea(trn_ea), .data(trn_data), .delta(trn_delta), .in_range(trn_in_range)
  );

  avd_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_tmatch (
    .vset(t_vset), .tset(t_tset), .tag(t_tag), .hit(t_hit), .way(t_way)
  );

  avd_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lmatch (
    .vset(l_vset), .tset(l_tset), .tag(l_tag), .hit(l_hit), .way(l_way)
  );

  avd_victim #(.WAYS(WAYS)) u_vict (
    .vset(t_vset), .aset(t_aset), .way(v_way)
  );

  // training decision
  always_comb begin
    tgt_way = t_hit ? t_way : v_way;
    tgt     = {t_idx, tgt_way};
    kind    = UPD_NONE;
    if (trn_vld && trn_in_range) begin
      if (!t_hit)                         kind = UPD_ALLOC;
      else if (delta_q[tgt] == trn_delta) kind = UPD_BUMP;
      else                                kind = UPD_RETRAIN;
    end
  end

  assign upd_en  = (kind != UPD_NONE);
  assign meta_en = (kind == UPD_ALLOC) || (kind == UPD_RETRAIN);

  // next state of valid, confidence and age
  always_comb begin
    valid_d = valid_q;
    conf_d  = conf_q;
    age_d   = age_q;
    case (kind)
      UPD_BUMP:    if (conf_q[tgt] != CONF_MAX) conf_d[tgt] = conf_q[tgt] + 1'b1;
      UPD_RETRAIN: conf_d[tgt] = '0;
      UPD_ALLOC: begin
        valid_d[tgt] = 1'b1;
        conf_d[tgt]  = '0;
      end
      default: ;
    endcase
    if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        logic [ENT_W-1:0] e;
        e = {t_idx, WAY_W'(w)};
        if (WAY_W'(w) == tgt_way)      age_d[e] = '0;
        else if (age_q[e] < age_q[tgt]) age_d[e] = age_q[e] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int e = 0; e < ENT; e++) begin
        conf_q[e] <= '0;
        age_q[e]  <= WAY_W'(e % WAYS);
      end
    end else if (upd_en) begin
      valid_q <= valid_d;
      conf_q  <= conf_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (meta_en) begin
      tag_q[tgt]   <= t_tag;
      delta_q[tgt] <= trn_delta;
    end
  end

  // lookup and value synthesis
  assign l_ent      = {l_idx, l_way};
  assign l_delta    = delta_q[l_ent];
  assign pred_ok    = lk_vld && l_hit && (conf_q[l_ent] >= CONF_TH_V);
  assign pred_val_d = lk_ea - {{(ADDR_W-DELTA_W){l_delta[DELTA_W-1]}}, l_delta};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_vld_q <= 1'b0;
    else        pred_vld_q <= pred_ok;
  end

  always_ff @(posedge clk) begin
    if (lk_vld) pred_value_q <= pred_val_d;
  end

  assign pred_vld   = pred_vld_q;
  assign pred_value = pred_value_q;
endmodule

// File: rtl/avd_predictor_chk.sv
// Property checker, attached to every avd_predictor instance.
module avd_predictor_chk #(
  parameter int ADDR_W  = 64,
  parameter int ENT     = 16,
  parameter int MAX_AVD = 65535
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trn_vld,
  input logic              trn_in_range,
  input logic              lk_vld,
  input logic [ADDR_W-1:0] lk_ea,
  input logic              pred_vld,
  input logic [ADDR_W-1:0] pred_value,
  input logic [ENT-1:0]    valid_q
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(MAX_AVD);

  function automatic logic in_lim(input logic [ADDR_W-1:0] d);
    return ($signed(d) <= $signed(LIM)) && ($signed(d) >= -$signed(LIM));
  endfunction

  // R10: a prediction only follows a lookup
  p_pred_after_lookup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> $past(lk_vld));

  // R2: the predicted value differs from the lookup address by an admissible delta
  p_pred_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> in_lim($past(lk_ea) - pred_value));

  // R3: an out-of-range training leaves the valid bits untouched
  p_filter_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_vld && !trn_in_range) |=> $stable(valid_q));

  // R8: without a training load the table does not change its valid bits
  p_lookup_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trn_vld |=> $stable(valid_q));

  // R6: at most one entry is allocated per training
  p_single_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trn_vld |=> ($countones(valid_q) <= $past($countones(valid_q)) + 1));
endmodule

bind avd_predictor avd_predictor_chk #(
  .ADDR_W(ADDR_W), .ENT(ENT), .MAX_AVD(MAX_AVD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trn_vld(trn_vld), .trn_in_range(trn_in_range),
  .lk_vld(lk_vld), .lk_ea(lk_ea), .pred_vld(pred_vld), .pred_value(pred_value),
  .valid_q(valid_q)
);

// File: tb/sim_avd_predictor.sv
module sim_avd_predictor;
  logic        clk;
  logic        rst_n;
  logic        trn_vld;
  logic [63:0] trn_pc, trn_ea, trn_data;
  logic        lk_vld;
  logic [63:0] lk_pc, lk_ea;
  logic        pred_vld;
  logic [63:0] pred_value;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  avd_predictor u0 (
    .clk(clk), .rst_n(rst_n),
    .trn_vld(trn_vld), .trn_pc(trn_pc), .trn_ea(trn_ea), .trn_data(trn_data),
    .lk_vld(lk_vld), .lk_pc(lk_pc), .lk_ea(lk_ea),
    .pred_vld(pred_vld), .pred_value(pred_value)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {is_lookup, pc, ea, data, exp_vld, exp_value}
  localparam int VW = 258;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 64'h100, 64'h2000, 64'h0,    1'b0, 64'h0},    // R1 empty
    {1'b0, 64'h100, 64'h1000, 64'h1040, 1'b0, 64'h0},    // alloc, delta -0x40
    {1'b1, 64'h100, 64'h3000, 64'h0,    1'b0, 64'h0},    // R4 conf 0
    {1'b0, 64'h100, 64'h1040, 64'h1080, 1'b0, 64'h0},
    {1'b1, 64'h100, 64'h3000, 64'h0,    1'b0, 64'h0},    // R4 conf 1
    {1'b0, 64'h100, 64'h1080, 64'h10c0, 1'b0, 64'h0},
    {1'b1, 64'h100, 64'h5000, 64'h0,    1'b1, 64'h5040}, // R2 R4 conf 2
    {1'b0, 64'h100, 64'h2000, 64'h1f00, 1'b0, 64'h0},    // R5 new delta
    {1'b1, 64'h100, 64'h6000, 64'h0,    1'b0, 64'h0},    // R5 conf reset
    {1'b0, 64'h201, 64'h4008, 64'h4000, 1'b0, 64'h0},    // leaf delta +8
    {1'b0, 64'h201, 64'h7008, 64'h7000, 1'b0, 64'h0},
    {1'b0, 64'h201, 64'h1108, 64'h1100, 1'b0, 64'h0},
    {1'b1, 64'h201, 64'h9008, 64'h0,    1'b1, 64'h9000}, // R2
    {1'b1, 64'h104, 64'h9000, 64'h0,    1'b0, 64'h0}     // R9 other tag
  };

  task automatic check(input string req, input logic ev, input logic [63:0] evl);
    n_chk++;
    if (pred_vld !== ev || (ev && pred_value !== evl)) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b value=%h, expected vld=%0b value=%h",
               req, pred_vld, pred_value, ev, evl);
    end
  endtask

  task automatic train(input logic [63:0] pc, input logic [63:0] ea, input logic [63:0] data);
    @(negedge clk);
    trn_vld = 1'b1; trn_pc = pc; trn_ea = ea; trn_data = data;
    @(negedge clk);
    trn_vld = 1'b0;
  endtask

  task automatic look(input logic [63:0] pc, input logic [63:0] ea,
                      input logic ev, input logic [63:0] evl, input string req);
    @(negedge clk);
    lk_vld = 1'b1; lk_pc = pc; lk_ea = ea;
    @(negedge clk);
    lk_vld = 1'b0;
    check(req, ev, evl);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trn_vld = 1'b0; lk_vld = 1'b0;
    trn_pc = '0; trn_ea = '0; trn_data = '0; lk_pc = '0; lk_ea = '0;
    repeat (3) @(negedge clk);
    check("R1 pred_vld in reset", 1'b0, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pred_vld after reset", 1'b0, 64'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      if (v[257]) look(v[256:193], v[192:129], v[64], v[63:0],
                       $sformatf("vector %0d (R1 R2 R4 R5 R9)", i));
      else        train(v[256:193], v[192:129], v[128:65]);
    end

    // R10: idle lookup port after a valid prediction
    look(64'h201, 64'h100, 1'b1, 64'hf8, "R10 setup");
    @(negedge clk);
    check("R10 no lookup, no prediction", 1'b0, 64'h0);

    // R3 boundaries: +65535 and -65535 accepted
    for (int k = 0; k < 3; k++) train(64'h202, 64'h20000, 64'h10001);
    look(64'h202, 64'h50000, 1'b1, 64'h40001, "R3 delta +max");
    for (int k = 0; k < 3; k++) train(64'h203, 64'h30000, 64'h3ffff);
    look(64'h203, 64'h60000, 1'b1, 64'h6ffff, "R3 delta -max");
    // R3: +65536 and -65536 rejected
    for (int k = 0; k < 3; k++) train(64'h302, 64'h20000, 64'h10000);
    for (int k = 0; k < 3; k++) train(64'h302, 64'h20000, 64'h30000);
    look(64'h302, 64'h20000, 1'b0, 64'h0, "R3 out of range not learned");
    train(64'h202, 64'h20000, 64'h10000);
    look(64'h202, 64'h50000, 1'b1, 64'h40001, "R3 existing entry unchanged");

    // R6: fill set 3 (0x203 already in way 0), then evict the LRU
    for (int k = 0; k < 3; k++) train(64'h043, 64'h100, 64'hfc);
    for (int k = 0; k < 3; k++) train(64'h083, 64'h100, 64'hfc);
    for (int k = 0; k < 3; k++) train(64'h0c3, 64'h100, 64'hfc);
    train(64'h203, 64'h30000, 64'h3ffff);
    train(64'h103, 64'h100, 64'hfc);
    look(64'h043, 64'h100, 1'b0, 64'h0, "R6 LRU way evicted");
    look(64'h203, 64'h60000, 1'b1, 64'h6ffff, "R6 recently trained way kept");
    look(64'h083, 64'h100, 1'b1, 64'hfc, "R6 other way kept");

    // R4 saturation: 1 alloc + 9 same-delta hits stays valid
    for (int k = 0; k < 10; k++) train(64'h000, 64'h200, 64'h1f0);
    look(64'h000, 64'h7000, 1'b1, 64'h6ff0, "R4 confidence saturates");

    // R7: same-cycle training is not seen by the lookup
    train(64'h001, 64'h500, 64'h4e0);
    train(64'h001, 64'h500, 64'h4e0);
    @(negedge clk);
    trn_vld = 1'b1; trn_pc = 64'h001; trn_ea = 64'h500; trn_data = 64'h4e0;
    lk_vld  = 1'b1; lk_pc  = 64'h001; lk_ea  = 64'h800;
    @(negedge clk);
    trn_vld = 1'b0; lk_vld = 1'b0;
    check("R7 lookup sees old confidence", 1'b0, 64'h0);
    look(64'h001, 64'h800, 1'b1, 64'h7e0, "R7 next lookup sees update");

    // R8: lookups do not allocate
    look(64'h140, 64'h900, 1'b0, 64'h0, "R8 miss lookup");
    look(64'h140, 64'h900, 1'b0, 64'h0, "R8 miss lookup");
    look(64'h140, 64'h900, 1'b0, 64'h0, "R8 miss lookup");
    train(64'h140, 64'h900, 64'h800);
    train(64'h140, 64'h900, 64'h800);
    look(64'h140, 64'h900, 1'b0, 64'h0, "R8 only two trainings counted");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule